// File: doc/BRIEF.md
# Interlocked Multiplexed Bus Read Target

This block is the responding side of a clockless, fully interlocked bus whose address and data share one set of lines. A master places an address on the shared lines and raises its read request. The target synchronises that request into its own clock domain, captures the address and answers with an acknowledge. It keeps the acknowledge up until the master withdraws the request. It then returns a fixed-length burst of words, one per four-edge exchange: it drives a word, raises a data-ready strobe, waits for the master's acknowledge, removes word and strobe, and waits for that acknowledge to fall.

The words come from a local memory or register array through a plain synchronous read port with one cycle of latency. The first word is read at the captured address. Each later word is read at the previous address plus one, modulo the address space. The target drives the shared lines only through a tri-state enable, which it raises for the data phase of each word and for no other time.

Top module: `async_bus_target`

## Requirements
- R1: During and right after synchronous reset, the acknowledge, data-ready and line-enable outputs are all low.
- R2: When the synchronised read request is seen high in idle, the target latches the low ADDR_W bits of the shared lines as the burst base address and raises its acknowledge. The first memory read of the burst uses this base address.
- R3: The acknowledge stays high as long as the read request stays high. It falls after the request is withdrawn, and it is never high at the same time as data-ready.
- R4: The line enable is low at all times except from the placement of a word until its removal. In particular, it is low whenever the acknowledge is high.
- R5: For each word, the line enable is high for at least one clock cycle before data-ready rises, and the driven word does not change while data-ready is high.
- R6: Word k of a burst (k = 0 to BEATS-1) equals the memory content at base + k, with the sum taken modulo 2^ADDR_W.
- R7: When the master's acknowledge is seen high during a strobe, the target drops both data-ready and the line enable. It places the next word only after that acknowledge has fallen again.
- R8: Each read request yields exactly BEATS words and exactly BEATS memory reads. Afterwards the target returns to idle and raises no further strobe.
- R9: A master acknowledge raised outside a data strobe has no effect. This covers acknowledges raised while idle and while the address acknowledge is held.
- R10: The memory read enable is a single-cycle pulse per word. The target expects read data on the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_read_i | input | 1 | Master read request, asynchronous |
| bus_mack_i | input | 1 | Master data acknowledge, asynchronous |
| bus_ad_i | input | DATA_W | Value currently on the shared address/data lines |
| bus_ad_o | output | DATA_W | Word the target places on the shared lines |
| bus_ad_oe_o | output | 1 | Tri-state enable for the shared lines |
| bus_ack_o | output | 1 | Target acknowledge of the address phase |
| bus_drdy_o | output | 1 | Data-ready strobe |
| mem_en_o | output | 1 | Local memory read enable |
| mem_addr_o | output | ADDR_W | Local memory read address |
| mem_rdata_i | input | DATA_W | Local memory read data, one cycle after enable |

## Verification
The bound checker watches the output relations on every cycle. Those relations are: acknowledge and data-ready never overlap, the lines are not driven while the acknowledge is held, data-ready never stands without the enable, the enable leads each strobe by a cycle, and the word holds still under the strobe. Only the bench scenarios can show the rest. That means the captured base address, the word values and the address wrap at the top of the space, the exact number of words and memory reads per request, the ordering against the master's request and acknowledge, and that stray master acknowledges outside a strobe change nothing.

// File: rtl/abs_pkg.sv
package abs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_ACK,
    ST_FETCH,
    ST_WAIT_DATA,
    ST_PRESENT,
    ST_STROBE,
    ST_DRAIN
  } abs_state_e;
endpackage

// File: rtl/abs_sync.sv
module abs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/abs_fetch.sv
module abs_fetch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              rd_req_i,
  input  logic              advance_i,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic              pend;

  always_ff @(posedge clk) begin
    if (rst)            cur_addr <= '0;
    else if (load_i)    cur_addr <= base_i;
    else if (advance_i) cur_addr <= cur_addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en_o   <= 1'b0;
      mem_addr_o <= '0;
      pend       <= 1'b0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      mem_en_o   <= rd_req_i;
      if (rd_req_i) mem_addr_o <= cur_addr;
      pend       <= mem_en_o;
      word_vld_o <= pend;
      if (pend) word_o <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/abs_ctrl.sv
module abs_ctrl
  import abs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              read_s_i,
  input  logic              mack_s_i,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              cap_o,
  output logic              rd_req_o,
  output logic              advance_o,
  output logic              ack_o,
  output logic              drdy_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] dout_o
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  abs_state_e state, nxt;
  logic [BW-1:0] beat;

  always_comb begin
    nxt       = state;
    cap_o     = 1'b0;
    rd_req_o  = 1'b0;
    advance_o = 1'b0;
    case (state)
      ST_IDLE:      if (read_s_i) begin cap_o = 1'b1; nxt = ST_ADDR_ACK; end
      ST_ADDR_ACK:  if (!read_s_i) nxt = ST_FETCH;
      ST_FETCH:     begin rd_req_o = 1'b1; nxt = ST_WAIT_DATA; end
      ST_WAIT_DATA: if (word_vld_i) nxt = ST_PRESENT;
      ST_PRESENT:   nxt = ST_STROBE;
      ST_STROBE:    if (mack_s_i) nxt = ST_DRAIN;
      ST_DRAIN: begin
        if (!mack_s_i) begin
          if (beat == LAST) nxt = ST_IDLE;
          else begin advance_o = 1'b1; nxt = ST_FETCH; end
        end
      end
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      beat   <= '0;
      ack_o  <= 1'b0;
      drdy_o <= 1'b0;
      oe_o   <= 1'b0;
      dout_o <= '0;
    end else begin
      state <= nxt;
      case (state)
        ST_IDLE:      if (read_s_i) ack_o <= 1'b1;
        ST_ADDR_ACK:  if (!read_s_i) begin ack_o <= 1'b0; beat <= '0; end
        ST_WAIT_DATA: if (word_vld_i) begin dout_o <= word_i; oe_o <= 1'b1; end
        ST_PRESENT:   drdy_o <= 1'b1;
        ST_STROBE:    if (mack_s_i) begin drdy_o <= 1'b0; oe_o <= 1'b0; end
        ST_DRAIN:     if (!mack_s_i && beat != LAST) beat <= beat + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/async_bus_target.sv
module async_bus_target #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BEATS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_read_i,
  input  logic              bus_mack_i,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe_o,
  output logic              bus_ack_o,
  output logic              bus_drdy_o,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [1:0]        sync_q;
  logic              cap, rd_req, advance, word_vld;
  logic [DATA_W-1:0] word;

  abs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({bus_mack_i, bus_read_i}),
    .sync_o  (sync_q)
  );

  abs_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .load_i      (cap),
    .base_i      (bus_ad_i[ADDR_W-1:0]),
    .rd_req_i    (rd_req),
    .advance_i   (advance),
    .mem_en_o    (mem_en_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .word_o      (word),
    .word_vld_o  (word_vld)
  );

  abs_ctrl #(.DATA_W(DATA_W), .BEATS(BEATS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .read_s_i   (sync_q[0]),
    .mack_s_i   (sync_q[1]),
    .word_vld_i (word_vld),
    .word_i     (word),
    .cap_o      (cap),
    .rd_req_o   (rd_req),
    .advance_o  (advance),
    .ack_o      (bus_ack_o),
    .drdy_o     (bus_drdy_o),
    .oe_o       (bus_ad_oe_o),
    .dout_o     (bus_ad_o)
  );
endmodule

// File: rtl/abs_checker.sv
module abs_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic              drdy,
  input logic              oe,
  input logic [DATA_W-1:0] dout
);
  AST_ACK_DRDY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ack && drdy)); // R3
  AST_NO_DRIVE_UNDER_ACK: assert property (@(posedge clk) disable iff (rst)
    ack |-> !oe); // R4
  AST_STROBE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    drdy |-> oe); // R7
  AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy) |-> $past(oe)); // R5
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (drdy && $past(drdy)) |-> $stable(dout)); // R5
endmodule

bind async_bus_target abs_checker #(.DATA_W(DATA_W)) u_abs_chk (
  .clk  (clk),
  .rst  (rst),
  .ack  (bus_ack_o),
  .drdy (bus_drdy_o),
  .oe   (bus_ad_oe_o),
  .dout (bus_ad_o)
);

// File: tb/tb_async_bus_target.sv
module tb_async_bus_target;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int TMO = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, mack = 1'b0;
  logic [DW-1:0] master_ad = '0;
  logic [DW-1:0] ad_o, ad_bus, mem_rdata = '0;
  logic oe, ack, drdy, mem_en;
  logic [AW-1:0] mem_addr;
  int checks = 0, fails = 0;
  int mem_cnt = 0;
  logic [AW-1:0] mem_log [64];

  always #4 clk = ~clk;

  assign ad_bus = oe ? ad_o : master_ad;

  async_bus_target #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NB)) dut (
    .clk(clk), .rst(rst), .bus_read_i(rd), .bus_mack_i(mack),
    .bus_ad_i(ad_bus), .bus_ad_o(ad_o), .bus_ad_oe_o(oe),
    .bus_ack_o(ack), .bus_drdy_o(drdy), .mem_en_o(mem_en),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [DW-1:0] wmodel(logic [AW-1:0] a);
    return {a ^ 8'hA5, a + 8'h3C};
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= wmodel(mem_addr);
      mem_log[mem_cnt % 64] <= mem_addr;
      mem_cnt <= mem_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ack == 1'b0, "R1 ack", ack, 0);
    chk(drdy == 1'b0, "R1 drdy", drdy, 0);
    chk(oe == 1'b0, "R1 oe", oe, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ack && !drdy && !oe, "R1 after release", {ack, drdy, oe}, 0);
  endtask

  task automatic t_burst(input logic [AW-1:0] base, input bit stray_mack);
    int start, w;
    bit prev_oe, bad;
    start = mem_cnt;
    master_ad = DW'(base);
    @(negedge clk);
    rd = 1'b1;
    w = 0;
    while (!ack && w < TMO) begin @(negedge clk); w++; end
    chk(ack, "R2 ack raised", ack, 1);
    if (stray_mack) mack = 1'b1;
    bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (!ack || oe || drdy) bad = 1;
    end
    chk(!bad, "R3/R4/R9 ack held, lines idle", {ack, oe, drdy}, 3'b100);
    mack = 1'b0;
    repeat (4) @(negedge clk);
    rd = 1'b0;
    master_ad = '0;
    w = 0;
    while (ack && w < TMO) begin @(negedge clk); w++; end
    chk(!ack, "R3 ack dropped", ack, 0);
    for (int k = 0; k < NB; k++) begin
      logic [DW-1:0] exp;
      exp = wmodel(base + AW'(k));
      prev_oe = oe;
      w = 0;
      while (!drdy && w < TMO) begin prev_oe = oe; @(negedge clk); w++; end
      chk(drdy, "R8 strobe present", drdy, 1);
      chk(prev_oe && oe, "R5 drive before strobe", {prev_oe, oe}, 2'b11);
      chk(ad_bus == exp, "R6 word value", ad_bus, exp);
      repeat (3) @(negedge clk);
      chk(drdy && ad_bus == exp, "R5 word held", ad_bus, exp);
      mack = 1'b1;
      w = 0;
      while (drdy && w < TMO) begin @(negedge clk); w++; end
      chk(!drdy && !oe, "R7 removal on mack", {drdy, oe}, 0);
      repeat (5) @(negedge clk);
      chk(!oe && !drdy, "R7 waits for mack low", {oe, drdy}, 0);
      mack = 1'b0;
    end
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (drdy || oe || ack) bad = 1;
    end
    chk(!bad, "R8 idle after burst", {drdy, oe, ack}, 0);
    chk(mem_cnt - start == NB, "R8 R10 memory read count", mem_cnt - start, NB);
    for (int k = 0; k < NB; k++)
      chk(mem_log[(start + k) % 64] == base + AW'(k), "R2 R6 memory address",
          mem_log[(start + k) % 64], base + AW'(k));
  endtask

  task automatic t_idle_mack();
    bit bad;
    bad = 0;
    mack = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (drdy || oe || ack || mem_en) bad = 1;
    end
    mack = 1'b0;
    repeat (5) @(negedge clk);
    chk(!bad && !drdy && !oe, "R9 idle mack ignored", {drdy, oe, ack}, 0);
  endtask

  task automatic t_enable_pulse();
    bit bad;
    int run;
    bad = 0;
    run = 0;
    fork
      t_burst(8'h40, 1'b0);
      begin
        repeat (400) begin
          @(negedge clk);
          if (mem_en) run++; else run = 0;
          if (run > 1) bad = 1;
        end
      end
    join
    chk(!bad, "R10 single-cycle enable", run, 1);
  endtask

  initial begin
    t_reset();
    t_burst(8'h10, 1'b0);
    t_burst(8'hFE, 1'b0);
    t_burst(8'h00, 1'b1);
    t_idle_mack();
    t_enable_pulse();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule